// File: doc/BRIEF.md
# Partition control register access gate

This block sits beside a processor's system-register access path. It judges one read or write aimed at the hypervisor-owned partition control register. A request carries the five encoding fields of the access, the privilege level it comes from (0 to 3), and a snapshot of the context bits that steer the decision:
- the three nested-virtualization flags;
- whether level 3 exists, and the level-3 trap-lower control;
- the two secure-debug undefined conditions (plain and priority);
- whether the partitioning feature is present, and whether its hypervisor control is advertised.

The block answers with one outcome code: direct access, undefined, trap to level 2, trap to level 3, or redirect to a memory offset. Trap outcomes also carry their syndrome class. Redirects also carry the offset.

For direct accesses the block owns the register. Only four bits are writable: ID-trap (31), share-user (8), level-1 map enable (1) and level-0 map enable (0). These four bits are driven out as live control outputs. Exception entry and the redirected memory access itself are left to the surrounding pipeline.

The controller is a three-state machine:
- ST_IDLE accepts a request. The transition IDLE→EVAL happens when `req_valid` is high.
- ST_EVAL compares the encoding, runs the priority chain and commits any direct write. The transition EVAL→RESP is unconditional.
- ST_RESP presents the response for one cycle. The transition RESP→IDLE is unconditional.

Top module: `pcr_access_gate`

## Requirements
- R1: Only the encoding op0=2'b11, op1=3'b100, CRn=4'b1010, CRm=4'b0100, op2=3'b000 selects the register. For any other encoding the response has `rsp_match`=0, outcome 0, syndrome 0, offset 0 and rdata 0, and the register is left unchanged.
- R2: If the feature-present input or the control-present input is 0, the outcome is undefined (code 1), whatever the level.
- R3: Any access from level 0 gives outcome undefined (code 1).
- R4: At level 1, when nested flags bit 2 and bit 0 are both set, the outcome is redirect (code 4), and `rsp_offset` is 12'h930. On every other outcome `rsp_offset` is 0.
- R5: At level 1, with nested flag bit 0 set and bit 2 clear, the outcome depends on level 3:
  - undefined (code 1) when level 3 exists, trap-lower is set and secure-debug-undefined holds;
  - trap to level 3 (code 3) when level 3 exists, trap-lower is set and secure-debug-undefined does not hold;
  - trap to level 2 (code 2) otherwise.

  Both trap codes carry syndrome class 6'h18, and every other outcome carries syndrome 0.
- R6: At level 1, with nested flag bit 0 clear, the outcome is undefined (code 1).
- R7: At level 2, when level 3 exists and trap-lower is set, the outcome is undefined if either the priority condition or secure-debug-undefined holds, and trap to level 3 (code 3) otherwise. In every other case at level 2 the access is direct (code 0).
- R8: At level 3 every access is direct (code 0), whatever the trap and secure-debug inputs are.
- R9: A direct write stores only bits 31, 8, 1 and 0. `rsp_rdata` returns the register for a direct read and is zero in all other bit positions.
- R10: While reset is asserted with the level-3-present input low, the ID-trap bit (bit 31) takes the value 1.
- R11: A request accepted in ST_IDLE gets `rsp_valid` for exactly one cycle, two clock edges after acceptance. `req_ready` is low from acceptance until the response has been given.
- R12: Any outcome other than direct leaves the register and the control outputs unchanged. For such outcomes, and for direct writes, `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_level | input | 2 | Privilege level of the access |
| req_wdata | input | DATA_W | Write data |
| nv_flags | input | 3 | Nested-virtualization flags |
| l3_present | input | 1 | Level 3 implemented; also selects the ID-trap reset value |
| trap_lower | input | 1 | Level-3 trap-lower control |
| sdd_undef | input | 1 | Secure-debug undefined condition |
| sdd_undef_prio | input | 1 | Secure-debug undefined priority condition |
| feat_present | input | 1 | Partitioning feature implemented |
| ctl_present | input | 1 | Hypervisor control advertised |
| rsp_valid | output | 1 | Response strobe |
| rsp_match | output | 1 | Encoding selected this register |
| rsp_outcome | output | 3 | 0 direct, 1 undefined, 2 trap L2, 3 trap L3, 4 redirect |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_offset | output | 12 | Redirect memory offset |
| rsp_rdata | output | DATA_W | Read data for direct reads |
| ctl_id_trap | output | 1 | Stored ID-trap bit |
| ctl_share_user | output | 1 | Stored share-user bit |
| ctl_v1_map | output | 1 | Stored level-1 map enable |
| ctl_v0_map | output | 1 | Stored level-0 map enable |

## Verification
A corrupted state register or request latch shows at the ports within two edges: `rsp_valid` appears in the wrong cycle or twice, or `req_ready` stays low, and the response-timing check sees it on the very next request. A wrong branch in the priority chain appears as a wrong outcome code, syndrome or offset in the response for that request. A mis-gated write enable or a wrong storage mask stays hidden until the next direct read or the next sample of the control outputs. For that reason every non-direct write with all-ones data is followed, before any other direct write, by a read-back and a control-output check.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    // Register select encoding
    localparam logic [1:0] SEL_OP0 = 2'b11;
    localparam logic [2:0] SEL_OP1 = 3'b100;
    localparam logic [3:0] SEL_CRN = 4'b1010;
    localparam logic [3:0] SEL_CRM = 4'b0100;
    localparam logic [2:0] SEL_OP2 = 3'b000;

    // Writable bit positions
    localparam int ID_TRAP_POS = 31;
    localparam int SHARE_POS   = 8;
    localparam int V1_MAP_POS  = 1;
    localparam int V0_MAP_POS  = 0;

    localparam int OFS_W = 12;
    localparam int SYN_W = 6;
    localparam logic [OFS_W-1:0] REDIR_OFFSET = 12'h930;
    localparam logic [SYN_W-1:0] TRAP_CLASS   = 6'h18;

    typedef enum logic [2:0] {
        OC_DIRECT   = 3'd0,
        OC_UNDEF    = 3'd1,
        OC_TRAP_L2  = 3'd2,
        OC_TRAP_L3  = 3'd3,
        OC_REDIRECT = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic       write;
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
        logic [1:0] level;
        logic [2:0] nv;
        logic       l3;
        logic       tl;
        logic       sdd;
        logic       sddp;
        logic       feat;
        logic       hasctl;
    } req_t;

endpackage

// File: rtl/pcr_enc_match.sv
module pcr_enc_match #(
    parameter logic [1:0] OP0 = 2'b11,
    parameter logic [2:0] OP1 = 3'b100,
    parameter logic [3:0] CRN = 4'b1010,
    parameter logic [3:0] CRM = 4'b0100,
    parameter logic [2:0] OP2 = 3'b000
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY = {OP0, OP1, CRN, CRM, OP2};

    logic [KEY_W-1:0] probe;
    assign probe = {op0, op1, crn, crm, op2};
    assign hit   = (probe == KEY);
endmodule

// File: rtl/pcr_perm_chain.sv
module pcr_perm_chain
    import pcr_pkg::*;
(
    input  logic [1:0]       level,
    input  logic [2:0]       nv,
    input  logic             l3,
    input  logic             tl,
    input  logic             sdd,
    input  logic             sddp,
    input  logic             feat,
    input  logic             hasctl,
    output outcome_e         oc,
    output logic [SYN_W-1:0] syn,
    output logic [OFS_W-1:0] ofs
);
    logic upper_trap;
    logic unused_nv_mid;

    assign upper_trap    = l3 & tl;
    assign unused_nv_mid = nv[1];

    always_comb begin
        oc = OC_UNDEF;
        if (feat && hasctl) begin
            unique case (level)
                2'd0: oc = OC_UNDEF;
                2'd1: begin
                    if (nv[2] && nv[0])
                        oc = OC_REDIRECT;
                    else if (nv[0])
                        oc = upper_trap ? (sdd ? OC_UNDEF : OC_TRAP_L3) : OC_TRAP_L2;
                    else
                        oc = OC_UNDEF;
                end
                2'd2: begin
                    if (upper_trap && sddp)
                        oc = OC_UNDEF;
                    else if (upper_trap)
                        oc = sdd ? OC_UNDEF : OC_TRAP_L3;
                    else
                        oc = OC_DIRECT;
                end
                default: oc = OC_DIRECT;
            endcase
        end
    end

    always_comb begin
        syn = '0;
        ofs = '0;
        if (oc == OC_TRAP_L2 || oc == OC_TRAP_L3) syn = TRAP_CLASS;
        if (oc == OC_REDIRECT)                    ofs = REDIR_OFFSET;
    end
endmodule

// File: rtl/pcr_ctl_store.sv
module pcr_ctl_store #(
    parameter int                DATA_W   = 64,
    parameter logic [DATA_W-1:0] WR_MASK  = '1,
    parameter int                TRAP_POS = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_trap_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^(wr_data & ~WR_MASK);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (WR_MASK[i]) begin : g_ff
            localparam bit IS_TRAP = (i == TRAP_POS);
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= IS_TRAP ? rst_trap_val : 1'b0;
                else if (wr_en)
                    bit_q <= wr_data[i];
            end
            assign q[i] = bit_q;
        end else begin : g_zero
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pcr_access_gate.sv
module pcr_access_gate
    import pcr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        req_level,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        nv_flags,
    input  logic              l3_present,
    input  logic              trap_lower,
    input  logic              sdd_undef,
    input  logic              sdd_undef_prio,
    input  logic              feat_present,
    input  logic              ctl_present,
    output logic              rsp_valid,
    output logic              rsp_match,
    output logic [2:0]        rsp_outcome,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic [OFS_W-1:0]  rsp_offset,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ctl_id_trap,
    output logic              ctl_share_user,
    output logic              ctl_v1_map,
    output logic              ctl_v0_map
);
    localparam logic [DATA_W-1:0] WMASK =
        (DATA_W'(1) << ID_TRAP_POS) | (DATA_W'(1) << SHARE_POS) |
        (DATA_W'(1) << V1_MAP_POS)  | (DATA_W'(1) << V0_MAP_POS);

    state_e            state_q, state_d;
    req_t              lat_q;
    logic [DATA_W-1:0] lat_wdata_q;

    logic              hit;
    outcome_e          chain_oc;
    logic [SYN_W-1:0]  chain_syn;
    logic [OFS_W-1:0]  chain_ofs;
    logic [DATA_W-1:0] store_q;
    logic              wr_en;

    logic              match_q;
    outcome_e          oc_q;
    logic [SYN_W-1:0]  syn_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] rdata_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture in IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q       <= '0;
            lat_wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            lat_q.write  <= req_write;
            lat_q.op0    <= req_op0;
            lat_q.op1    <= req_op1;
            lat_q.crn    <= req_crn;
            lat_q.crm    <= req_crm;
            lat_q.op2    <= req_op2;
            lat_q.level  <= req_level;
            lat_q.nv     <= nv_flags;
            lat_q.l3     <= l3_present;
            lat_q.tl     <= trap_lower;
            lat_q.sdd    <= sdd_undef;
            lat_q.sddp   <= sdd_undef_prio;
            lat_q.feat   <= feat_present;
            lat_q.hasctl <= ctl_present;
            lat_wdata_q  <= req_wdata;
        end
    end

    pcr_enc_match #(
        .OP0(SEL_OP0), .OP1(SEL_OP1), .CRN(SEL_CRN), .CRM(SEL_CRM), .OP2(SEL_OP2)
    ) u_match (
        .op0(lat_q.op0), .op1(lat_q.op1), .crn(lat_q.crn),
        .crm(lat_q.crm), .op2(lat_q.op2), .hit(hit)
    );

    pcr_perm_chain u_chain (
        .level (lat_q.level),
        .nv    (lat_q.nv),
        .l3    (lat_q.l3),
        .tl    (lat_q.tl),
        .sdd   (lat_q.sdd),
        .sddp  (lat_q.sddp),
        .feat  (lat_q.feat),
        .hasctl(lat_q.hasctl),
        .oc    (chain_oc),
        .syn   (chain_syn),
        .ofs   (chain_ofs)
    );

    // Commit a direct write on EVAL -> RESP
    assign wr_en = (state_q == ST_EVAL) && hit && lat_q.write && (chain_oc == OC_DIRECT);

    pcr_ctl_store #(
        .DATA_W  (DATA_W),
        .WR_MASK (WMASK),
        .TRAP_POS(ID_TRAP_POS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_trap_val(~l3_present),
        .wr_en       (wr_en),
        .wr_data     (lat_wdata_q),
        .q           (store_q)
    );

    // Decision capture in EVAL
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            oc_q    <= OC_DIRECT;
            syn_q   <= '0;
            ofs_q   <= '0;
            rdata_q <= '0;
        end else if (state_q == ST_EVAL) begin
            match_q <= hit;
            oc_q    <= hit ? chain_oc  : OC_DIRECT;
            syn_q   <= hit ? chain_syn : '0;
            ofs_q   <= hit ? chain_ofs : '0;
            rdata_q <= (hit && !lat_q.write && chain_oc == OC_DIRECT) ? store_q : '0;
        end
    end

    // Outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        rsp_valid      = (state_q == ST_RESP);
        rsp_match      = rsp_valid ? match_q : 1'b0;
        rsp_outcome    = rsp_valid ? oc_q    : OC_DIRECT;
        rsp_syndrome   = rsp_valid ? syn_q   : '0;
        rsp_offset     = rsp_valid ? ofs_q   : '0;
        rsp_rdata      = rsp_valid ? rdata_q : '0;
        ctl_id_trap    = store_q[ID_TRAP_POS];
        ctl_share_user = store_q[SHARE_POS];
        ctl_v1_map     = store_q[V1_MAP_POS];
        ctl_v0_map     = store_q[V0_MAP_POS];
    end
endmodule

// File: rtl/pcr_access_gate_chk.sv
module pcr_access_gate_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_match,
    input logic [2:0]        rsp_outcome,
    input logic [5:0]        rsp_syndrome,
    input logic [11:0]       rsp_offset,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              ctl_id_trap,
    input logic              ctl_share_user,
    input logic              ctl_v1_map,
    input logic              ctl_v0_map
);
    localparam logic [DATA_W-1:0] KEEP = (DATA_W'(1) << 31) | (DATA_W'(1) << 8) | DATA_W'(3);

    logic [3:0] ctl_vec;
    assign ctl_vec = {ctl_id_trap, ctl_share_user, ctl_v1_map, ctl_v0_map};

    p_resp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid);

    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_trap_syndrome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_outcome == 3'd2 || rsp_outcome == 3'd3) ?
                       (rsp_syndrome == 6'h18) : (rsp_syndrome == 6'h0)));

    p_redirect_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_outcome == 3'd4) ? (rsp_offset == 12'h930) : (rsp_offset == 12'h0)));

    p_nomatch_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_match) |-> (rsp_outcome == 3'd0 && rsp_rdata == '0));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata & ~KEEP) == '0);

    p_nondirect_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome != 3'd0) |-> ($stable(ctl_vec) && rsp_rdata == '0));
endmodule

bind pcr_access_gate pcr_access_gate_chk #(.DATA_W(DATA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_match     (rsp_match),
    .rsp_outcome   (rsp_outcome),
    .rsp_syndrome  (rsp_syndrome),
    .rsp_offset    (rsp_offset),
    .rsp_rdata     (rsp_rdata),
    .ctl_id_trap   (ctl_id_trap),
    .ctl_share_user(ctl_share_user),
    .ctl_v1_map    (ctl_v1_map),
    .ctl_v0_map    (ctl_v0_map)
);

// File: tb/test_pcr_access_gate.sv
module test_pcr_access_gate;
    localparam int W = 64;
    localparam logic [W-1:0] KEEP = 64'h0000_0000_8000_0103;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [1:0] req_op0 = '0, req_level = '0;
    logic [2:0] req_op1 = '0, req_op2 = '0, nv_flags = '0;
    logic [3:0] req_crn = '0, req_crm = '0;
    logic [W-1:0] req_wdata = '0;
    logic l3_present = 1'b0, trap_lower = 1'b0, sdd_undef = 1'b0, sdd_undef_prio = 1'b0;
    logic feat_present = 1'b1, ctl_present = 1'b1;
    logic rsp_valid, rsp_match;
    logic [2:0] rsp_outcome;
    logic [5:0] rsp_syndrome;
    logic [11:0] rsp_offset;
    logic [W-1:0] rsp_rdata;
    logic ctl_id_trap, ctl_share_user, ctl_v1_map, ctl_v0_map;

    always #2 clk = ~clk;

    pcr_access_gate #(.DATA_W(W)) i_pcr_access_gate (.*);

    typedef struct {
        string        tag;
        logic         match;
        logic [2:0]   oc;
        logic [5:0]   syn;
        logic [11:0]  ofs;
        logic [W-1:0] rdata;
        logic [W-1:0] rmask;
        int           due;
    } exp_t;

    exp_t exp_q[$];
    int tests = 0, fails = 0, cyc = 0;
    logic [W-1:0] mdl = '0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2:0] model_oc(input logic [1:0] lvl);
        logic up;
        up = l3_present & trap_lower;
        if (!feat_present || !ctl_present) return 3'd1;        // R2
        case (lvl)
            2'd0: return 3'd1;                                  // R3
            2'd1: begin
                if (nv_flags[2] && nv_flags[0]) return 3'd4;    // R4
                if (!nv_flags[0]) return 3'd1;                  // R6
                if (up) return sdd_undef ? 3'd1 : 3'd3;         // R5
                return 3'd2;
            end
            2'd2: begin                                         // R7
                if (up && sdd_undef_prio) return 3'd1;
                if (up) return sdd_undef ? 3'd1 : 3'd3;
                return 3'd0;
            end
            default: return 3'd0;                               // R8
        endcase
    endfunction

    task automatic send_enc(input string tag, input bit wr, input logic [1:0] lvl,
                            input logic [W-1:0] wd, input logic [1:0] o0, input logic [2:0] o1,
                            input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                            input logic [W-1:0] rmask);
        exp_t e;
        logic hit;
        while (!req_ready) @(negedge clk);
        hit = (o0 == 2'b11) && (o1 == 3'b100) && (cn == 4'b1010) && (cm == 4'b0100) && (o2 == 3'b000);
        e.tag   = tag;
        e.match = hit;
        e.oc    = hit ? model_oc(lvl) : 3'd0;
        e.syn   = (e.oc == 3'd2 || e.oc == 3'd3) ? 6'h18 : 6'h0;
        e.ofs   = (e.oc == 3'd4) ? 12'h930 : 12'h0;
        e.rdata = (hit && e.oc == 3'd0 && !wr) ? mdl : '0;
        e.rmask = rmask;
        e.due   = cyc + 2;
        if (hit && e.oc == 3'd0 && wr) mdl = wd & KEEP;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_level = lvl; req_wdata = wd;
        req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send(input string tag, input bit wr, input logic [1:0] lvl, input logic [W-1:0] wd);
        send_enc(tag, wr, lvl, wd, 2'b11, 3'b100, 4'b1010, 4'b0100, 3'b000, ONES);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_ctl(input string tag, input logic [3:0] want);
        logic [3:0] got;
        got = {ctl_id_trap, ctl_share_user, ctl_v1_map, ctl_v0_map};
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: ctl outputs actual=%b expected=%b", tag, got, want);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R11: unexpected response actual=valid expected=none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_match !== e.match || rsp_outcome !== e.oc || rsp_syndrome !== e.syn ||
                    rsp_offset !== e.ofs || ((rsp_rdata & e.rmask) !== (e.rdata & e.rmask)) ||
                    cyc != e.due) begin
                    fails++;
                    $display("FAIL %s: actual m=%b oc=%0d syn=%h ofs=%h rd=%h cyc=%0d expected m=%b oc=%0d syn=%h ofs=%h rd=%h cyc=%0d",
                             e.tag, rsp_match, rsp_outcome, rsp_syndrome, rsp_offset, rsp_rdata & e.rmask, cyc,
                             e.match, e.oc, e.syn, e.ofs, e.rdata & e.rmask, e.due);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R11: watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11: idle after reset actual=%b%b expected=10", req_ready, rsp_valid);
        end
        // R10: only bit 31 is defined after reset with level 3 absent
        mdl = 64'h8000_0000;
        send_enc("R10", 0, 2'd2, '0, 2'b11, 3'b100, 4'b1010, 4'b0100, 3'b000, 64'h8000_0000);
        drain();

        l3_present = 1'b1;
        send("R9", 1, 2'd3, ONES);
        send("R9", 0, 2'd3, '0);
        drain();
        check_ctl("R9", 4'b1111);

        send("R7", 1, 2'd2, 64'h0000_0001);
        send("R7", 0, 2'd2, '0);

        // R1: foreign encodings
        send_enc("R1", 1, 2'd3, ONES, 2'b11, 3'b100, 4'b1010, 4'b0101, 3'b000, ONES);
        send_enc("R1", 1, 2'd3, ONES, 2'b11, 3'b011, 4'b1010, 4'b0100, 3'b000, ONES);
        send_enc("R1", 0, 2'd3, '0,   2'b11, 3'b100, 4'b1010, 4'b0100, 3'b001, ONES);
        send("R1", 0, 2'd3, '0);

        feat_present = 1'b0; send("R2", 1, 2'd3, ONES);
        feat_present = 1'b1; ctl_present = 1'b0; send("R2", 0, 2'd3, '0);
        ctl_present = 1'b1;

        send("R3", 1, 2'd0, ONES);

        nv_flags = 3'b101; send("R4", 1, 2'd1, ONES);
        nv_flags = 3'b111; send("R4", 0, 2'd1, '0);

        nv_flags = 3'b001; l3_present = 1'b1; trap_lower = 1'b0; send("R5", 1, 2'd1, ONES);
        l3_present = 1'b0; trap_lower = 1'b1; send("R5", 1, 2'd1, ONES);
        l3_present = 1'b1; send("R5", 1, 2'd1, ONES);
        sdd_undef = 1'b1; send("R5", 0, 2'd1, '0);
        sdd_undef = 1'b0; nv_flags = 3'b011; send("R5", 1, 2'd1, ONES);

        nv_flags = 3'b100; send("R6", 1, 2'd1, ONES);
        nv_flags = 3'b000; send("R6", 0, 2'd1, '0);
        nv_flags = 3'b110; send("R6", 1, 2'd1, ONES);

        nv_flags = 3'b000;
        sdd_undef_prio = 1'b1; send("R7", 1, 2'd2, ONES);
        sdd_undef_prio = 1'b0; sdd_undef = 1'b1; send("R7", 1, 2'd2, ONES);
        sdd_undef = 1'b0; send("R7", 1, 2'd2, ONES);
        l3_present = 1'b0; send("R7", 0, 2'd2, '0);
        l3_present = 1'b1;

        send("R12", 0, 2'd3, '0);
        drain();
        check_ctl("R12", 4'b0001);

        sdd_undef = 1'b1; sdd_undef_prio = 1'b1;
        send("R8", 1, 2'd3, 64'hFFFF_0000_8000_0100);
        send("R8", 0, 2'd3, '0);
        drain();
        check_ctl("R8", 4'b1100);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule